// File: doc/BRIEF.md
# Processor Presence Bitmap with Hotplug Event Status

This block keeps one presence bit for every processor slot, up to a parameterised maximum (256 by default), packed eight to a byte. The bytes are readable over a simple byte-wide I/O port. A second small register window on the same port holds general-purpose event status and enable bytes. Each processor hot-add or hot-remove request updates the presence bit of the selected processor. It also latches a sticky status bit, so that system software gets an event and can rescan the bitmap.

When reset is released, the bitmap is seeded from a count of processors present at boot, so processors `0 .. count-1` read as present. The event status bytes are write-one-to-clear and the enable bytes are plain read/write. A level output is raised while any enabled status bit is set. Creating or destroying the processors themselves is not part of this block.

Top module: `cpu_presence_regs`

## Requirements
- R1: During synchronous reset (`rst_n` low at a clock edge), presence bit i is loaded with 1 exactly when i < `present_count`. A count above `MAX_CPUS` marks every slot present, and all event status and enable bits clear to 0.
- R2: Reading address `MAP_BASE + n` returns processors 8n to 8n+7, with the lowest-numbered processor in bit 0. Bit positions at or above `MAX_CPUS` always read 0.
- R3: A clock edge with `add_stb` high and `rem_stb` low sets the presence bit of processor `cpu_idx` and sets status bit `HP_BIT` (2) of status byte 0.
- R4: A clock edge with `rem_stb` high clears the presence bit of processor `cpu_idx` and also sets status bit `HP_BIT` of status byte 0.
- R5: When `add_stb` and `rem_stb` are both high at the same edge, the removal takes effect: the bit ends up cleared.
- R6: Writes to the bitmap addresses have no effect on the bitmap.
- R7: Status bytes sit at `GPE_BASE + k` for k < `GPE_BYTES`. A write clears each status bit whose data bit is 1 and leaves bits written with 0 unchanged.
- R8: If a hotplug strobe and a write that clears bit `HP_BIT` land at the same edge, the bit stays set.
- R9: Enable bytes sit at `GPE_BASE + GPE_BYTES + k`. They store the written byte and read it back unchanged.
- R10: `gpe_event` is high exactly while some status bit and its matching enable bit are both 1.
- R11: A strobe whose `cpu_idx` is not below `MAX_CPUS` changes no presence bit and no status bit.
- R12: Reads of addresses outside both register windows return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| present_count | input | $clog2(MAX_CPUS+1) | Number of processors present at boot, sampled during reset |
| cpu_idx | input | $clog2(MAP_BYTES*8) | Processor targeted by the hotplug strobes |
| add_stb | input | 1 | Hot-add request, one cycle |
| rem_stb | input | 1 | Hot-remove request, one cycle |
| io_addr | input | ADDR_W | Byte address for reads and writes |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Combinational read data for `io_addr` |
| gpe_event | output | 1 | High while any enabled status bit is set |

## Verification
The assertions rely on two things about the inputs. Both hotplug strobes refer to the `cpu_idx` presented in the same cycle. `present_count` holds steady while reset is asserted. The bench drives every input on the falling clock edge and holds it for exactly one cycle, so each strobe or write is seen at a single rising edge. Reset is held for two edges with a fixed count. The bench runs a small configuration of 12 processors, in which index values 12 to 15 exercise the out-of-range path. It sweeps every boot count, including counts above the maximum, and every index for add, remove and both together.

// File: rtl/cpu_presence_regs.sv
module cpu_presence_regs #(
  parameter int MAX_CPUS  = 256,
  parameter int GPE_BYTES = 2,
  parameter int ADDR_W    = 8,
  parameter int MAP_BASE  = 0,
  parameter int GPE_BASE  = 32,
  parameter int HP_BIT    = 2,
  localparam int MAP_BYTES = (MAX_CPUS + 7) / 8,
  localparam int MAP_BITS  = MAP_BYTES * 8,
  localparam int IDX_W     = $clog2(MAP_BITS),
  localparam int CNT_W     = $clog2(MAX_CPUS + 1),
  localparam int GPE_BITS  = GPE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  present_count,
  input  logic [IDX_W-1:0]  cpu_idx,
  input  logic              add_stb,
  input  logic              rem_stb,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              gpe_event
);

  logic [MAP_BITS-1:0] map_q;
  logic [GPE_BITS-1:0] sts_q;
  logic [GPE_BITS-1:0] en_q;

  logic idx_ok, hot;
  assign idx_ok = (32'(cpu_idx) < 32'(MAX_CPUS));
  assign hot    = (add_stb | rem_stb) & idx_ok;

  int addr_i, map_ofs, gpe_ofs;
  logic map_hit, gpe_hit;
  assign addr_i  = 32'(io_addr);
  assign map_ofs = addr_i - MAP_BASE;
  assign gpe_ofs = addr_i - GPE_BASE;
  assign map_hit = (addr_i >= MAP_BASE) && (map_ofs < MAP_BYTES);
  assign gpe_hit = (addr_i >= GPE_BASE) && (gpe_ofs < 2 * GPE_BYTES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MAP_BITS; i++)
        map_q[i] <= (i < MAX_CPUS) && (32'(present_count) > i);
    end else if (hot) begin
      map_q[cpu_idx] <= !rem_stb;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      if (io_wr && gpe_hit) begin
        for (int k = 0; k < GPE_BYTES; k++) begin
          if (gpe_ofs == k)
            sts_q[k*8 +: 8] <= sts_q[k*8 +: 8] & ~io_wdata;
          if (gpe_ofs == GPE_BYTES + k)
            en_q[k*8 +: 8] <= io_wdata;
        end
      end
      if (hot)
        sts_q[HP_BIT] <= 1'b1;
    end
  end

  always_comb begin
    io_rdata = 8'h00;
    if (map_hit) begin
      for (int n = 0; n < MAP_BYTES; n++)
        if (map_ofs == n) io_rdata = map_q[n*8 +: 8];
    end else if (gpe_hit) begin
      for (int k = 0; k < GPE_BYTES; k++) begin
        if (gpe_ofs == k)             io_rdata = sts_q[k*8 +: 8];
        if (gpe_ofs == GPE_BYTES + k) io_rdata = en_q[k*8 +: 8];
      end
    end
  end

  assign gpe_event = |(sts_q & en_q);

  assert_add_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (add_stb && !rem_stb && idx_ok) |=> map_q[$past(cpu_idx)]);

  assert_rem_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_stb && idx_ok) |=> !map_q[$past(cpu_idx)]);

  assert_event_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hot |=> sts_q[HP_BIT]);

  assert_map_only_by_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !hot |=> $stable(map_q));

  assert_status_sets_by_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[HP_BIT]) |-> $past(hot));

  assert_range_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((add_stb || rem_stb) && !idx_ok) |=> $stable(map_q));

endmodule

// File: tb/cpu_presence_regs_bench.sv
`timescale 1ns/1ps
module cpu_presence_regs_bench;
  localparam int MAXC = 12;
  localparam int MAPB = 4;
  localparam int GPEB = 16;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [3:0] present_count = 0;
  logic [3:0] cpu_idx = 0;
  logic       add_stb = 0, rem_stb = 0;
  logic [5:0] io_addr = 0;
  logic       io_wr = 0;
  logic [7:0] io_wdata = 0;
  logic [7:0] io_rdata;
  logic       gpe_event;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] m;

  always #2 clk = ~clk;

  cpu_presence_regs #(.MAX_CPUS(MAXC), .GPE_BYTES(2), .ADDR_W(6),
                      .MAP_BASE(MAPB), .GPE_BASE(GPEB), .HP_BIT(2)) u_cpu_presence_regs (
    .clk(clk), .rst_n(rst_n), .present_count(present_count), .cpu_idx(cpu_idx),
    .add_stb(add_stb), .rem_stb(rem_stb), .io_addr(io_addr), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .gpe_event(gpe_event));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic rd(input string req, input logic [5:0] a, input logic [7:0] exp);
    @(negedge clk);
    io_addr = a;
    #1 check(req, io_rdata, exp);
  endtask

  task automatic check_map(input string req);
    rd(req, 6'(MAPB), m[7:0]);
    rd(req, 6'(MAPB + 1), {4'h0, m[11:8]});
  endtask

  task automatic cycle(input bit a, input bit r, input logic [3:0] idx,
                       input bit w, input logic [5:0] addr, input logic [7:0] d);
    @(negedge clk);
    add_stb = a; rem_stb = r; cpu_idx = idx;
    io_wr = w; io_addr = addr; io_wdata = d;
    @(negedge clk);
    add_stb = 0; rem_stb = 0; io_wr = 0;
  endtask

  task automatic do_reset(input logic [3:0] cnt);
    @(negedge clk);
    rst_n = 0; present_count = cnt;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #150000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 / R2: every boot count, including counts above the maximum
    for (int c = 0; c < 16; c++) begin
      do_reset(4'(c));
      m = (c >= MAXC) ? 16'h0FFF : 16'((1 << c) - 1);
      check_map("R1 preload");
      rd("R1 status reset", 6'(GPEB), 8'h00);
      rd("R1 enable reset", 6'(GPEB + 2), 8'h00);
      check("R1 event reset", {7'd0, gpe_event}, 8'h00);
    end

    do_reset(4'd5);
    m = 16'h001F;
    // R9 enable read/write
    cycle(0, 0, 0, 1, 6'(GPEB + 2), 8'hA5);
    cycle(0, 0, 0, 1, 6'(GPEB + 3), 8'h3C);
    rd("R9 enable byte0", 6'(GPEB + 2), 8'hA5);
    rd("R9 enable byte1", 6'(GPEB + 3), 8'h3C);
    cycle(0, 0, 0, 1, 6'(GPEB + 2), 8'h00);
    rd("R9 enable rewrite", 6'(GPEB + 2), 8'h00);

    // R3 / R11: hot-add sweep
    for (int i = 0; i < 16; i++) begin
      cycle(1, 0, 4'(i), 0, 0, 0);
      if (i < MAXC) m[i] = 1'b1;
      check_map("R3 add");
      rd(i < MAXC ? "R3 add status" : "R11 range status", 6'(GPEB), i < MAXC ? 8'h04 : 8'h00);
      cycle(0, 0, 0, 1, 6'(GPEB), 8'h04);
      rd("R7 clear", 6'(GPEB), 8'h00);
    end

    // R4 / R11: hot-remove sweep
    for (int i = 0; i < 16; i++) begin
      cycle(0, 1, 4'(i), 0, 0, 0);
      if (i < MAXC) m[i] = 1'b0;
      check_map("R4 remove");
      rd(i < MAXC ? "R4 remove status" : "R11 range status", 6'(GPEB), i < MAXC ? 8'h04 : 8'h00);
      cycle(0, 0, 0, 1, 6'(GPEB), 8'h04);
    end

    // R5: both strobes together, starting from a set bit
    for (int i = 0; i < MAXC; i++) begin
      cycle(1, 0, 4'(i), 0, 0, 0);
      cycle(1, 1, 4'(i), 0, 0, 0);
      m[i] = 1'b0;
      check_map("R5 remove wins");
    end
    cycle(1, 0, 4'd3, 0, 0, 0);
    m[3] = 1'b1;

    // R6: bitmap writes ignored
    cycle(0, 0, 0, 1, 6'(MAPB), 8'h00);
    cycle(0, 0, 0, 1, 6'(MAPB + 1), 8'hFF);
    check_map("R6 write ignored");

    // R7: only bits written with 1 clear
    rd("R7 pending", 6'(GPEB), 8'h04);
    cycle(0, 0, 0, 1, 6'(GPEB), 8'hFB);
    rd("R7 zero keeps", 6'(GPEB), 8'h04);
    cycle(0, 0, 0, 1, 6'(GPEB + 1), 8'hFF);
    rd("R7 other byte", 6'(GPEB), 8'h04);

    // R10: event output
    cycle(0, 0, 0, 1, 6'(GPEB + 2), 8'h04);
    #1 check("R10 event on", {7'd0, gpe_event}, 8'h01);
    cycle(0, 0, 0, 1, 6'(GPEB + 2), 8'hFB);
    #1 check("R10 other enables", {7'd0, gpe_event}, 8'h00);
    cycle(0, 0, 0, 1, 6'(GPEB + 2), 8'h04);
    cycle(0, 0, 0, 1, 6'(GPEB), 8'h04);
    #1 check("R10 event off", {7'd0, gpe_event}, 8'h00);

    // R8: event and clear at the same edge
    cycle(0, 1, 4'd3, 1, 6'(GPEB), 8'h04);
    m[3] = 1'b0;
    rd("R8 set beats clear", 6'(GPEB), 8'h04);
    check_map("R8 map");

    // R12 / R2: unmapped addresses
    rd("R12 low", 6'h00, 8'h00);
    rd("R12 high", 6'h3F, 8'h00);
    rd("R12 gap", 6'(MAPB + 2), 8'h00);
    rd("R12 past gpe", 6'(GPEB + 4), 8'h00);
    rd("R2 upper nibble", 6'(MAPB + 1), {4'h0, m[11:8]});

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule